// File: doc/BRIEF.md
# Transmit FIFO Release and Flush Controller

This block decides when a frame sitting in a byte-wide transmit FIFO may be handed to the MAC transmitter. It also carries out a software flush of that FIFO. It keeps no data itself. It counts the bytes that are written and popped, the number of complete frames that are buffered, and the number of transmit statuses the host has not yet taken. From those counts it raises a start request towards the MAC.

Release follows one of two rules. In cut-through mode, a frame starts once the bytes it holds in the FIFO exceed a threshold, which is chosen by a 3-bit code. A shorter frame starts as soon as its last byte is written. In store-and-forward mode, a frame starts only once it is complete.

A flush empties the control state at once. A frame the MAC has already accepted is not pulled back. Its missing bytes show up as an underflow. The flush flag stays high until the FIFO is empty, no frame is in flight, and every pending status has been acknowledged. While the flag is high, control writes are refused.

Top module: `txthr_ctrl`

## Requirements
- R1: `fill_level` resets to 0. It rises by one for each `wr_en` byte accepted while below DEPTH (default 512) and falls by one for each byte popped. A write at DEPTH is dropped.
- R2: Threshold codes select byte counts as follows: 0→64, 1→128, 2→192, 3→256, 4→40, 5→32, 6→24, 7→16.
- R3: In cut-through mode, with no complete frame buffered, `tx_start` rises two cycles after the write that makes the level strictly greater than the threshold. It stays high until `tx_ack` is sampled high.
- R4: In cut-through mode, a frame whose end byte (`wr_eof`=1) has been written is released even when it is shorter than the threshold.
- R5: With `sf_q`=1, no frame starts until its end byte is written, whatever the level.
- R6: A control write with `cfg_flush`=1 sets `flush_busy` and returns `fill_level` to 0 one cycle later. A start request not yet acknowledged is withdrawn.
- R7: A frame already acknowledged through `tx_ack` is not aborted by a flush. The MAC keeps reading it.
- R8: Every frame that ends adds one pending status, and each `stat_ack` removes one. `flush_busy` falls one cycle after the level is 0, no status is pending and no frame is in flight.
- R9: `ttc_q` and `sf_q` reset to 0 and load from `cfg_ttc` and `cfg_sf` on `cfg_we`. While `flush_busy` is high, control writes and FIFO writes are ignored.
- R10: A `rd_en` during transmission with the level at 0 gives a one-cycle `tx_underflow` pulse and ends that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A byte is written into the FIFO |
| wr_eof | input | 1 | The written byte ends its frame |
| rd_en | input | 1 | The MAC pops a byte |
| rd_eof | input | 1 | The popped byte carries the end marker (from storage) |
| tx_ack | input | 1 | The MAC accepts the start request |
| stat_ack | input | 1 | The host takes one transmit status |
| cfg_we | input | 1 | Control write strobe |
| cfg_ttc | input | 3 | Threshold code to write |
| cfg_sf | input | 1 | Store-and-forward enable to write |
| cfg_flush | input | 1 | Flush request to write |
| tx_start | output | 1 | Start request to the MAC |
| tx_underflow | output | 1 | Read from an empty FIFO mid-frame |
| flush_busy | output | 1 | Flush in progress |
| ttc_q | output | 3 | Active threshold code |
| sf_q | output | 1 | Active store-and-forward enable |
| fill_level | output | 10 | Bytes held in the FIFO |

## Verification
The hardest case to reach is a flush that arrives while the MAC is partway through a frame it has already accepted. The bench sets a small threshold and writes a frame with no end marker, so the frame starts in cut-through mode. It acknowledges the start, pops a few bytes, and then writes the flush. The next pop must find an empty FIFO and raise underflow. The flush must stay busy until that frame's status is acknowledged.

// File: rtl/txthr_pkg.sv
package txthr_pkg;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_REQ  = 2'd1,
        TS_SEND = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [2:0] ttc;
        logic       sf;
        logic       flush;
    } ctl_t;

    // Codes 0..3 step upward by 64; codes 4..7 step downward by 8 from 40.
    function automatic logic [8:0] thr_bytes(input logic [2:0] code);
        logic [8:0] c9;
        c9 = {6'd0, code};
        if (!code[2])
            return (c9 + 9'd1) << 6;
        else
            return 9'd16 + ((9'd7 - c9) << 3);
    endfunction

endpackage

// File: rtl/txthr_cfg.sv
module txthr_cfg
    import txthr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  ctl_t wdata,
    input  logic done,
    output ctl_t ctl_q,
    output logic flush_start
);
    assign flush_start = we && !ctl_q.flush && wdata.flush;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (we && !ctl_q.flush)
            ctl_q <= wdata;
        else if (ctl_q.flush && done)
            ctl_q.flush <= 1'b0;
    end
endmodule

// File: rtl/txthr_occ.sv
module txthr_occ #(
    parameter int DEPTH = 512,
    parameter int PEND_W = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_eof,
    input  logic             pop,
    input  logic             pop_eof,
    input  logic             frame_end,
    input  logic             stat_ack,
    input  logic             busy,
    input  logic             flush_start,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] frames,
    output logic [PEND_W-1:0] pend
);
    logic wr_acc;
    logic eof_in, eof_out;

    assign wr_acc  = wr_en && !busy && !flush_start && (level < LVL_W'(DEPTH));
    assign eof_in  = wr_acc && wr_eof;
    assign eof_out = pop && pop_eof && (frames != '0);

    always_ff @(posedge clk) begin
        if (rst || flush_start) begin
            level  <= '0;
            frames <= '0;
        end else begin
            level  <= level + LVL_W'(wr_acc) - LVL_W'(pop);
            frames <= frames + LVL_W'(eof_in) - LVL_W'(eof_out);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= pend + PEND_W'(frame_end) - PEND_W'(stat_ack && (pend != '0));
    end
endmodule

// File: rtl/txthr_rel.sv
module txthr_rel
    import txthr_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] frames,
    input  logic [2:0]       ttc,
    input  logic             sf,
    input  logic             busy,
    input  logic             flush_start,
    input  logic             tx_ack,
    input  logic             rd_en,
    input  logic             rd_eof,
    output logic             tx_start,
    output logic             pop,
    output logic             frame_end,
    output logic             in_flight,
    output logic             underflow
);
    tx_state_e state;
    logic      release_ok;
    logic      starve;

    assign release_ok = (frames != '0) ||
                        (!sf && (level > LVL_W'(thr_bytes(ttc))));
    assign starve    = (state == TS_SEND) && rd_en && (level == '0);
    assign pop       = (state == TS_SEND) && rd_en && (level != '0);
    assign frame_end = starve || (pop && rd_eof);
    assign tx_start  = (state == TS_REQ);
    assign in_flight = (state == TS_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TS_IDLE;
            underflow <= 1'b0;
        end else begin
            underflow <= starve;
            unique case (state)
                TS_IDLE: if (!busy && !flush_start && release_ok) state <= TS_REQ;
                TS_REQ:  if (flush_start) state <= TS_IDLE;
                         else if (tx_ack) state <= TS_SEND;
                TS_SEND: if (frame_end) state <= TS_IDLE;
                default: state <= TS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txthr_ctrl.sv
module txthr_ctrl
    import txthr_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PEND_W = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_eof,
    input  logic             rd_en,
    input  logic             rd_eof,
    input  logic             tx_ack,
    input  logic             stat_ack,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_ttc,
    input  logic             cfg_sf,
    input  logic             cfg_flush,
    output logic             tx_start,
    output logic             tx_underflow,
    output logic             flush_busy,
    output logic [2:0]       ttc_q,
    output logic             sf_q,
    output logic [LVL_W-1:0] fill_level
);
    ctl_t              ctl_q;
    ctl_t              wdata;
    logic              flush_start;
    logic              done;
    logic              pop, frame_end, in_flight;
    logic [LVL_W-1:0]  frames;
    logic [PEND_W-1:0] pend;

    assign wdata = '{ttc: cfg_ttc, sf: cfg_sf, flush: cfg_flush};
    assign done  = (fill_level == '0) && (pend == '0) && !in_flight;

    txthr_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(wdata), .done(done),
        .ctl_q(ctl_q), .flush_start(flush_start)
    );

    txthr_occ #(.DEPTH(DEPTH), .PEND_W(PEND_W)) u_occ (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_eof(wr_eof),
        .pop(pop), .pop_eof(rd_eof), .frame_end(frame_end),
        .stat_ack(stat_ack), .busy(ctl_q.flush), .flush_start(flush_start),
        .level(fill_level), .frames(frames), .pend(pend)
    );

    txthr_rel #(.LVL_W(LVL_W)) u_rel (
        .clk(clk), .rst(rst), .level(fill_level), .frames(frames),
        .ttc(ctl_q.ttc), .sf(ctl_q.sf), .busy(ctl_q.flush),
        .flush_start(flush_start), .tx_ack(tx_ack), .rd_en(rd_en),
        .rd_eof(rd_eof), .tx_start(tx_start), .pop(pop),
        .frame_end(frame_end), .in_flight(in_flight), .underflow(tx_underflow)
    );

    assign flush_busy = ctl_q.flush;
    assign ttc_q      = ctl_q.ttc;
    assign sf_q       = ctl_q.sf;
endmodule

// File: rtl/txthr_ctrl_chk.sv
module txthr_ctrl_chk #(
    parameter int DEPTH = 512,
    parameter int LVL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             tx_ack,
    input logic             cfg_we,
    input logic             cfg_flush,
    input logic             tx_start,
    input logic             tx_underflow,
    input logic             flush_busy,
    input logic [2:0]       ttc_q,
    input logic             sf_q,
    input logic [LVL_W-1:0] fill_level
);
    a_r1_level_cap: assert property (@(posedge clk) disable iff (rst)
        fill_level <= LVL_W'(DEPTH));

    a_r3_start_held: assert property (@(posedge clk) disable iff (rst)
        tx_start && !tx_ack && !(cfg_we && cfg_flush) |=> tx_start);

    a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_busy) |-> fill_level == '0);

    a_r8_done_empty: assert property (@(posedge clk) disable iff (rst)
        $fell(flush_busy) |-> fill_level == '0);

    a_r9_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        flush_busy |=> $stable(ttc_q) && $stable(sf_q));

    a_r10_underflow_cause: assert property (@(posedge clk) disable iff (rst)
        tx_underflow |-> $past(rd_en) && ($past(fill_level) == '0));
endmodule

bind txthr_ctrl txthr_ctrl_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .tx_ack(tx_ack), .cfg_we(cfg_we),
    .cfg_flush(cfg_flush), .tx_start(tx_start), .tx_underflow(tx_underflow),
    .flush_busy(flush_busy), .ttc_q(ttc_q), .sf_q(sf_q), .fill_level(fill_level)
);

// File: tb/sim_txthr_ctrl.sv
module sim_txthr_ctrl;
    localparam int DEPTH = 512;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, wr_eof = 0, rd_en = 0, rd_eof = 0, tx_ack = 0, stat_ack = 0;
    logic cfg_we = 0, cfg_sf = 0, cfg_flush = 0;
    logic [2:0] cfg_ttc = '0;
    logic tx_start, tx_underflow, flush_busy, sf_q;
    logic [2:0] ttc_q;
    logic [LVL_W-1:0] fill_level;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    txthr_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_eof(wr_eof), .rd_en(rd_en),
        .rd_eof(rd_eof), .tx_ack(tx_ack), .stat_ack(stat_ack), .cfg_we(cfg_we),
        .cfg_ttc(cfg_ttc), .cfg_sf(cfg_sf), .cfg_flush(cfg_flush),
        .tx_start(tx_start), .tx_underflow(tx_underflow), .flush_busy(flush_busy),
        .ttc_q(ttc_q), .sf_q(sf_q), .fill_level(fill_level)
    );

    // {code[2:0], sf, eof_on_last, expect_start, nbytes[8:0]}
    localparam int NV = 14;
    localparam logic [14:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 1'b0, 9'd64},
        {3'd0, 1'b0, 1'b0, 1'b1, 9'd65},
        {3'd1, 1'b0, 1'b0, 1'b0, 9'd128},
        {3'd1, 1'b0, 1'b0, 1'b1, 9'd129},
        {3'd2, 1'b0, 1'b0, 1'b1, 9'd193},
        {3'd3, 1'b0, 1'b0, 1'b1, 9'd257},
        {3'd4, 1'b0, 1'b0, 1'b0, 9'd40},
        {3'd4, 1'b0, 1'b0, 1'b1, 9'd41},
        {3'd5, 1'b0, 1'b0, 1'b1, 9'd33},
        {3'd6, 1'b0, 1'b0, 1'b0, 9'd24},
        {3'd7, 1'b0, 1'b0, 1'b1, 9'd17},
        {3'd6, 1'b0, 1'b1, 1'b1, 9'd5},
        {3'd7, 1'b1, 1'b0, 1'b0, 9'd100},
        {3'd7, 1'b1, 1'b1, 1'b1, 9'd100}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic set_cfg(input logic [2:0] c, input logic sf, input logic fl);
        cfg_we = 1; cfg_ttc = c; cfg_sf = sf; cfg_flush = fl;
        cyc(1);
        cfg_we = 0; cfg_flush = 0;
    endtask

    task automatic write_bytes(input int n, input logic eof_last);
        for (int i = 0; i < n; i++) begin
            wr_en = 1; wr_eof = eof_last && (i == n - 1);
            cyc(1);
        end
        wr_en = 0; wr_eof = 0;
    endtask

    task automatic read_bytes(input int n, input logic eof_last);
        for (int i = 0; i < n; i++) begin
            rd_en = 1; rd_eof = eof_last && (i == n - 1);
            cyc(1);
        end
        rd_en = 0; rd_eof = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1, R9: reset state
        do_reset();
        chk("R1 reset level", int'(fill_level), 0);
        chk("R9 reset ttc", int'(ttc_q), 0);
        chk("R9 reset sf", int'(sf_q), 0);
        chk("R8 reset busy", int'(flush_busy), 0);
        chk("R3 reset start", int'(tx_start), 0);

        // R2 R3 R4 R5 threshold table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            set_cfg(VEC[v][14:12], VEC[v][11], 1'b0);
            write_bytes(int'(VEC[v][8:0]), VEC[v][10]);
            cyc(2);
            chk($sformatf("R2 R3 R4 R5 vec%0d start", v), int'(tx_start), int'(VEC[v][9]));
            chk($sformatf("R1 vec%0d level", v), int'(fill_level), int'(VEC[v][8:0]));
        end

        // R3 handshake hold, R1 pop, R8 pending status, R9 locked cfg
        do_reset();
        set_cfg(3'd7, 1'b0, 1'b0);
        write_bytes(20, 1'b1);
        cyc(4);
        chk("R3 start held without ack", int'(tx_start), 1);
        tx_ack = 1; cyc(1); tx_ack = 0;
        chk("R3 start drops after ack", int'(tx_start), 0);
        read_bytes(20, 1'b1);
        chk("R1 level after pops", int'(fill_level), 0);
        cyc(1);
        chk("R4 no restart after frame", int'(tx_start), 0);
        set_cfg(3'd7, 1'b0, 1'b1);
        chk("R6 busy after flush", int'(flush_busy), 1);
        set_cfg(3'd5, 1'b1, 1'b0);
        chk("R9 ttc locked while busy", int'(ttc_q), 7);
        chk("R9 sf locked while busy", int'(sf_q), 0);
        chk("R8 busy while status pending", int'(flush_busy), 1);
        stat_ack = 1; cyc(1); stat_ack = 0;
        cyc(1);
        chk("R8 busy clears after status taken", int'(flush_busy), 0);
        set_cfg(3'd5, 1'b1, 1'b0);
        chk("R9 ttc loads when idle", int'(ttc_q), 5);

        // R1 overflow drop, R6 flush, R9 writes ignored while busy
        do_reset();
        set_cfg(3'd0, 1'b1, 1'b0);
        write_bytes(DEPTH + 3, 1'b0);
        chk("R1 level capped at depth", int'(fill_level), DEPTH);
        set_cfg(3'd0, 1'b1, 1'b1);
        chk("R6 level zero after flush", int'(fill_level), 0);
        chk("R6 busy set", int'(flush_busy), 1);
        wr_en = 1; cyc(1); wr_en = 0;
        chk("R9 write ignored while busy", int'(fill_level), 0);
        chk("R8 busy clears when empty", int'(flush_busy), 0);

        // R6 pending request withdrawn
        do_reset();
        set_cfg(3'd7, 1'b0, 1'b0);
        write_bytes(20, 1'b0);
        cyc(2);
        chk("R3 start before flush", int'(tx_start), 1);
        set_cfg(3'd7, 1'b0, 1'b1);
        chk("R6 request withdrawn", int'(tx_start), 0);
        chk("R6 level cleared", int'(fill_level), 0);

        // R10 underflow in cut-through
        do_reset();
        set_cfg(3'd7, 1'b0, 1'b0);
        write_bytes(17, 1'b0);
        cyc(2);
        tx_ack = 1; cyc(1); tx_ack = 0;
        read_bytes(17, 1'b0);
        chk("R10 no underflow yet", int'(tx_underflow), 0);
        rd_en = 1; cyc(1); rd_en = 0;
        chk("R10 underflow pulse", int'(tx_underflow), 1);
        cyc(1);
        chk("R10 underflow one cycle", int'(tx_underflow), 0);
        chk("R10 frame ended", int'(tx_start), 0);

        // R7 flush during an accepted frame
        do_reset();
        set_cfg(3'd7, 1'b0, 1'b0);
        write_bytes(30, 1'b0);
        cyc(2);
        tx_ack = 1; cyc(1); tx_ack = 0;
        read_bytes(5, 1'b0);
        set_cfg(3'd7, 1'b0, 1'b1);
        chk("R7 level flushed", int'(fill_level), 0);
        chk("R7 busy", int'(flush_busy), 1);
        rd_en = 1; cyc(1); rd_en = 0;
        chk("R7 accepted frame keeps reading, underflows", int'(tx_underflow), 1);
        chk("R8 busy until status taken", int'(flush_busy), 1);
        stat_ack = 1; cyc(1); stat_ack = 0;
        cyc(1);
        chk("R8 busy clears", int'(flush_busy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule